// File: doc/BRIEF.md
# Two-Pulse RF Gate Sequencer

This block times a repeating pair of RF transmit pulses. Four programmable durations, each counted in clock cycles, set the sequence. The first is the width of the first pulse. The second is the quiet gap before the second pulse. The third is the width of the second pulse. The fourth is the minimum rest after the second pulse before the pair may repeat. A rising edge on the start input launches the sequence. A mode input chooses between one pass and endless repetition.

During the two pulse phases the block drives a gate output high. While the gate is high, it passes an externally generated carrier sample to the first DAC channel. At all other times that channel carries the zero code. A one-cycle trigger marks the start of each repetition. A select input picks what the second DAC channel shows: either the same gated carrier or the trigger, scaled to full-scale.

DAC samples are two's complement, so zero is the mid-scale code. A busy output reports a sequence in progress. An active-low asynchronous reset returns the block to idle.

Top module: `pulse_seq_gen`

## Requirements
- R1: After a launch, the phases run in this fixed order: pulse one (gate high), gap (gate low), pulse two (gate high), rest (gate low). Each lasts the number of cycles held on its duration input when the phase is entered. The first pulse cycle is visible on the outputs in the cycle after the clock edge that samples the start rise.
- R2: A duration input of 0 produces a phase of exactly one cycle.
- R3: A sequence launches only when the block is idle and start_i is 1 at a clock edge after being 0 at the previous edge. A start held high never launches a second sequence, and start toggles during a run have no effect on the timeline.
- R4: With continuous_i at 0, one pass of the four phases runs, and busy_o falls in the cycle after the rest phase ends.
- R5: With continuous_i at 1, the first pulse phase follows the rest phase immediately, with no start edge.
- R6: If continuous_i is cleared during a run, the pass in progress completes, and the block then goes idle.
- R7: trigger_o is high for exactly the first cycle of each first-pulse phase and low at all other times.
- R8: dac_a_o equals carrier_i while gate_o is 1 and is 0 otherwise.
- R9: With dacb_sel_i at 0, dac_b_o equals dac_a_o. With dacb_sel_i at 1, dac_b_o is the maximum positive code (0x7FFF at 16 bits) while trigger_o is 1 and 0 otherwise.
- R10: busy_o is 1 from the first pulse cycle through the last rest cycle. Asserting rst_ni low forces gate_o, trigger_o and busy_o to 0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, acts on its rising edge |
| continuous_i | input | 1 | 1 = repeat, 0 = single pass |
| dacb_sel_i | input | 1 | DAC B source: 0 = gated carrier, 1 = trigger |
| p1_len_i | input | CNT_W | First pulse width in cycles |
| gap_len_i | input | CNT_W | Gap between the pulses in cycles |
| p2_len_i | input | CNT_W | Second pulse width in cycles |
| rest_len_i | input | CNT_W | Minimum rest before repeat in cycles |
| carrier_i | input | SAMPLE_W | Carrier sample, two's complement |
| gate_o | output | 1 | Transmit gate |
| trigger_o | output | 1 | One-cycle mark at each repetition start |
| busy_o | output | 1 | Sequence in progress |
| dac_a_o | output | SAMPLE_W | Gated carrier |
| dac_b_o | output | SAMPLE_W | Selected second channel |

## Verification
Phase state is registered, so gate_o, trigger_o and busy_o change one clock edge after the edge that samples a start rise or a phase end. The bench therefore counts cycle k=0 from the first falling edge after the launching edge and, at each falling edge, compares the outputs with a timeline it computes from the effective durations. dac_a_o and dac_b_o are combinational from the gate state, the trigger state and the inputs, so they are checked at the same falling edge as the gate. Every input change is made on a falling edge, half a cycle away from any sampling edge.

// File: rtl/pulse_seq_pkg.sv
package pulse_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ON1,
    PH_GAP,
    PH_ON2,
    PH_REST
  } phase_e;
endpackage

// File: rtl/pulse_seq_edge.sv
module pulse_seq_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_q <= 1'b0;
    else         level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/pulse_seq_fsm.sv
module pulse_seq_fsm
  import pulse_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             continuous_i,
  input  logic [CNT_W-1:0] p1_len_i,
  input  logic [CNT_W-1:0] gap_len_i,
  input  logic [CNT_W-1:0] p2_len_i,
  input  logic [CNT_W-1:0] rest_len_i,
  output logic             gate_o,
  output logic             trigger_o,
  output logic             busy_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             trig_q, trig_d;
  logic [CNT_W-1:0] len_sel;

  // zero length counts as one cycle: load len-1, floor at 0
  always_comb begin
    unique case (phase_d)
      PH_ON1:  len_sel = p1_len_i;
      PH_GAP:  len_sel = gap_len_i;
      PH_ON2:  len_sel = p2_len_i;
      PH_REST: len_sel = rest_len_i;
      default: len_sel = '0;
    endcase
  end

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    trig_d  = 1'b0;
    if (phase_q == PH_IDLE) begin
      if (launch_i) phase_d = PH_ON1;
    end else if (cnt_q == '0) begin
      unique case (phase_q)
        PH_ON1:  phase_d = PH_GAP;
        PH_GAP:  phase_d = PH_ON2;
        PH_ON2:  phase_d = PH_REST;
        PH_REST: phase_d = continuous_i ? PH_ON1 : PH_IDLE;
        default: phase_d = PH_IDLE;
      endcase
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
    if (phase_d != phase_q || (phase_q == PH_REST && phase_d == PH_ON1)) begin
      cnt_d  = (len_sel == '0) ? '0 : len_sel - 1'b1;
      trig_d = (phase_d == PH_ON1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      trig_q  <= trig_d;
    end
  end

  assign gate_o    = (phase_q == PH_ON1) || (phase_q == PH_ON2);
  assign busy_o    = (phase_q != PH_IDLE);
  assign trigger_o = trig_q;
endmodule

// File: rtl/pulse_seq_dac_mux.sv
module pulse_seq_dac_mux #(
  parameter int SAMPLE_W = 16
) (
  input  logic                gate_i,
  input  logic                trigger_i,
  input  logic                sel_i,
  input  logic [SAMPLE_W-1:0] carrier_i,
  output logic [SAMPLE_W-1:0] dac_a_o,
  output logic [SAMPLE_W-1:0] dac_b_o
);
  localparam logic [SAMPLE_W-1:0] FULL_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

  assign dac_a_o = gate_i ? carrier_i : '0;
  assign dac_b_o = sel_i ? (trigger_i ? FULL_POS : '0) : dac_a_o;
endmodule

// File: rtl/pulse_seq_gen.sv
module pulse_seq_gen #(
  parameter int CNT_W    = 32,
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                continuous_i,
  input  logic                dacb_sel_i,
  input  logic [CNT_W-1:0]    p1_len_i,
  input  logic [CNT_W-1:0]    gap_len_i,
  input  logic [CNT_W-1:0]    p2_len_i,
  input  logic [CNT_W-1:0]    rest_len_i,
  input  logic [SAMPLE_W-1:0] carrier_i,
  output logic                gate_o,
  output logic                trigger_o,
  output logic                busy_o,
  output logic [SAMPLE_W-1:0] dac_a_o,
  output logic [SAMPLE_W-1:0] dac_b_o
);
  logic start_rise;

  pulse_seq_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (start_i),
    .rise_o  (start_rise)
  );

  pulse_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (start_rise),
    .continuous_i (continuous_i),
    .p1_len_i     (p1_len_i),
    .gap_len_i    (gap_len_i),
    .p2_len_i     (p2_len_i),
    .rest_len_i   (rest_len_i),
    .gate_o       (gate_o),
    .trigger_o    (trigger_o),
    .busy_o       (busy_o)
  );

  pulse_seq_dac_mux #(.SAMPLE_W(SAMPLE_W)) u_mux (
    .gate_i    (gate_o),
    .trigger_i (trigger_o),
    .sel_i     (dacb_sel_i),
    .carrier_i (carrier_i),
    .dac_a_o   (dac_a_o),
    .dac_b_o   (dac_b_o)
  );
endmodule

// File: rtl/pulse_seq_gen_chk.sv
module pulse_seq_gen_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic                dacb_sel_i,
  input logic                gate_o,
  input logic                trigger_o,
  input logic                busy_o,
  input logic [SAMPLE_W-1:0] dac_a_o,
  input logic [SAMPLE_W-1:0] dac_b_o
);
  // R3
  launch_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !$past(start_i)) |=> (busy_o && trigger_o));
  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(start_i && !$past(start_i))) |=> !busy_o);
  // R7
  trig_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trigger_o |=> !trigger_o);
  // R7
  trig_in_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trigger_o |-> (gate_o && busy_o));
  // R8
  dac_a_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (dac_a_o == '0));
  // R9
  dac_b_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dacb_sel_i && !busy_o) |-> (dac_b_o == '0));
  // R10
  gate_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> busy_o);
endmodule

bind pulse_seq_gen pulse_seq_gen_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .dacb_sel_i (dacb_sel_i),
  .gate_o     (gate_o),
  .trigger_o  (trigger_o),
  .busy_o     (busy_o),
  .dac_a_o    (dac_a_o),
  .dac_b_o    (dac_b_o)
);

// File: tb/pulse_seq_gen_tb.sv
module pulse_seq_gen_tb;
  localparam int CNT_W    = 32;
  localparam int SAMPLE_W = 16;
  localparam time CLK_P   = 20ns;
  localparam logic [SAMPLE_W-1:0] FS = 16'h7FFF;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, continuous_i = 1'b0, dacb_sel_i = 1'b0;
  logic [CNT_W-1:0] p1_len_i = '0, gap_len_i = '0, p2_len_i = '0, rest_len_i = '0;
  logic [SAMPLE_W-1:0] carrier_i = '0;
  logic gate_o, trigger_o, busy_o;
  logic [SAMPLE_W-1:0] dac_a_o, dac_b_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  pulse_seq_gen #(.CNT_W(CNT_W), .SAMPLE_W(SAMPLE_W)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic int eff(int l);
    return (l == 0) ? 1 : l;
  endfunction

  // cycle k within a pass of effective lengths e1..e4
  task automatic chk_cycle(int k, int e1, int e2, int e3, int e4, bit busy_exp);
    int  ph;
    bit  g, t;
    logic [SAMPLE_W-1:0] a, b;
    ph = k % (e1 + e2 + e3 + e4);
    g  = busy_exp && ((ph < e1) || (ph >= e1 + e2 && ph < e1 + e2 + e3));
    t  = busy_exp && (ph == 0);
    a  = g ? carrier_i : '0;
    b  = dacb_sel_i ? (t ? FS : '0) : a;
    chk("R1/R2 gate", gate_o, g);
    chk("R7 trigger", trigger_o, t);
    chk("R4/R10 busy", busy_o, busy_exp);
    chk("R8 dac_a", dac_a_o, a);
    chk("R9 dac_b", dac_b_o, b);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int e1, e2, e3, e4, tp;
    // R10 reset state
    #(CLK_P*2);
    chk("R10 reset gate", gate_o, 0);
    chk("R10 reset busy", busy_o, 0);
    chk("R10 reset trigger", trigger_o, 0);
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep all durations 0..3, single pass (R1 R2 R3 R4 R7 R8 R9)
    for (int c = 0; c < 256; c++) begin
      p1_len_i   = 32'(c & 3);
      gap_len_i  = 32'((c >> 2) & 3);
      p2_len_i   = 32'((c >> 4) & 3);
      rest_len_i = 32'((c >> 6) & 3);
      dacb_sel_i = c[0] ^ c[3];
      carrier_i  = 16'(16'h1357 + c * 97);
      continuous_i = 1'b0;
      e1 = eff(c & 3); e2 = eff((c >> 2) & 3);
      e3 = eff((c >> 4) & 3); e4 = eff((c >> 6) & 3);
      tp = e1 + e2 + e3 + e4;
      start_i = 1'b1;
      // start held high past the end: R3 no retrigger, R4 idle after one pass
      for (int k = 0; k < tp + 3; k++) begin
        @(negedge clk_i);
        chk_cycle(k, e1, e2, e3, e4, k < tp);
      end
      start_i = 1'b0;
      @(negedge clk_i);
    end

    // R5 continuous repeat, R3 toggles mid-run ignored, R6 clear mid-run
    p1_len_i = 2; gap_len_i = 1; p2_len_i = 3; rest_len_i = 0;
    e1 = 2; e2 = 1; e3 = 3; e4 = 1; tp = 7;
    dacb_sel_i = 1'b1; carrier_i = 16'hA5C3;
    continuous_i = 1'b1;
    start_i = 1'b1;
    for (int k = 0; k < 3*tp + 4; k++) begin
      @(negedge clk_i);
      chk_cycle(k, e1, e2, e3, e4, k < 3*tp);
      if (k == 2) start_i = 1'b0;
      if (k == 3) start_i = 1'b1;
      if (k == 2*tp + 3) continuous_i = 1'b0;
      if (k == 9) dacb_sel_i = 1'b0;
    end
    start_i = 1'b0;
    @(negedge clk_i);

    // R10 asynchronous reset mid-run
    continuous_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10 running before reset", busy_o, 1);
    rst_ni = 1'b0;
    #1;
    chk("R10 reset gate", gate_o, 0);
    chk("R10 reset busy", busy_o, 0);
    chk("R10 reset trigger", trigger_o, 0);
    start_i = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 idle after reset", busy_o, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule